// File: doc/BRIEF.md
# I2C SCL High/Low Timing Generator

This block produces the serial clock waveform of an I2C master. The clock is built from two phase counters. The high phase is stretched by a programmable spike-suppression length plus a fixed overhead of seven cycles. The low phase runs for its count plus one cycle. Three speed modes (standard, fast, high-speed) each keep their own pair of high and low counts. A captured mode value picks the pair that drives the bus. A second strobe marks the cycle in each low phase at which SDA may change, a programmable number of cycles after SCL falls.

Software programs the counts through a simple write port while the block is disabled. When the enable input is raised, the generator starts with a full high phase and then alternates. While the enable is low, SCL is released, the phase state is cleared, and register writes and mode changes are accepted. While the enable is high, register writes and mode changes are ignored, so the waveform cannot change in the middle of a phase.

Top module: `scl_timing_gen`

## Requirements
- R1: While enabled, every SCL high phase (phase_high_o = 1) lasts exactly HCNT + SPK + 7 clock cycles. HCNT is the high count of the active mode and SPK is the spike length of that mode.
- R2: While enabled, every SCL low phase (scl_low_o = 1) lasts exactly LCNT + 1 clock cycles, with LCNT the low count of the active mode. At most one of scl_low_o and phase_high_o is 1 in any cycle.
- R3: The mode value is captured from mode_i on every clock edge at which en_i is low. The codes are 0 = standard, 1 = fast, 2 = high-speed, and 3 = treated as fast. The pairs are written at addresses 0/1 (standard high/low), 2/3 (fast high/low) and 4/5 (high-speed high/low).
- R4: The spike length written at address 6 applies to the standard and fast modes. The one written at address 7 applies to high-speed mode.
- R5: In each low phase, sda_strobe_o is 1 for exactly one cycle. Counting the first low cycle as index 0, that cycle is index min(HOLD, LCNT), where HOLD is the hold register written at address 8.
- R6: A write of zero to the hold register (address 8) is ignored, and the previous hold value stays in effect.
- R7: While en_i is high, register writes and changes on mode_i have no effect on the waveform.
- R8: One clock edge after en_i is seen low, scl_low_o and phase_high_o are both 0. The first phase after enabling is a full-length high phase.
- R9: After reset, all three pairs hold the default counts (high 8, low 12), both spike lengths hold 1, the hold register holds 3, and the mode is fast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; all counts are in its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable; low releases SCL and opens the register port |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address (0..8) |
| wr_data_i | input | 16 | Register write data |
| mode_i | input | 2 | Speed mode select, captured while disabled |
| scl_low_o | output | 1 | 1 = drive SCL low (low phase) |
| phase_high_o | output | 1 | 1 = SCL released in the high phase |
| sda_strobe_o | output | 1 | One-cycle pulse where SDA may change |

## Verification
The bench measures phase lengths for each mode, with and without a spike length. A design that mixed up the pairs or the spike registers would show a high phase that is off by the difference between modes. The bench uses a hold value larger than the low count, and an all-zero configuration that gives a 7-cycle high and 1-cycle low. A design without the clip to LCNT would never pulse the strobe, and an off-by-one counter would stretch the single low cycle. The bench writes and changes the mode while enabled, writes a zero hold value, and drops the enable in the middle of a phase. These stimuli expose a design that lets writes leak through, overwrites the hold with zero, or resumes a stale phase instead of starting a fresh high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HIGH = 2'd1,
      PH_LOW  = 2'd2
   } phase_e;

   localparam int unsigned NUM_PAIRS   = 3;
   localparam int unsigned NUM_SPK     = 2;
   localparam int unsigned PHASE_FIXED = 7;

   localparam logic [1:0] MODE_STD  = 2'd0;
   localparam logic [1:0] MODE_FAST = 2'd1;
   localparam logic [1:0] MODE_HS   = 2'd2;

   localparam int unsigned ADDR_SPK_BASE = 6;
   localparam int unsigned ADDR_HOLD     = 8;

endpackage

// File: rtl/scl_gen_regs.sv
module scl_gen_regs
   import scl_gen_pkg::*;
#(
   parameter int unsigned CW       = 16,
   parameter int unsigned AW       = 4,
   parameter int unsigned DEF_HCNT = 8,
   parameter int unsigned DEF_LCNT = 12,
   parameter int unsigned DEF_SPK  = 1,
   parameter int unsigned DEF_HOLD = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [CW-1:0] wr_data_i,
   input  logic [1:0]    mode_i,
   output logic [CW-1:0] sel_hcnt_o,
   output logic [CW-1:0] sel_lcnt_o,
   output logic [CW-1:0] sel_spk_o,
   output logic [CW-1:0] hold_o
);

   logic          wr_ok;
   logic [1:0]    mode_q;
   logic [CW-1:0] hcnt_all [NUM_PAIRS];
   logic [CW-1:0] lcnt_all [NUM_PAIRS];
   logic [CW-1:0] spk_all  [NUM_SPK];
   logic [CW-1:0] hold_q;

   assign wr_ok = wr_en_i & ~en_i;

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic [CW-1:0] h_q;
      logic [CW-1:0] l_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            h_q <= CW'(DEF_HCNT);
            l_q <= CW'(DEF_LCNT);
         end else if (wr_ok) begin
            if (wr_addr_i == AW'(2 * p))     h_q <= wr_data_i;
            if (wr_addr_i == AW'(2 * p + 1)) l_q <= wr_data_i;
         end
      end
      assign hcnt_all[p] = h_q;
      assign lcnt_all[p] = l_q;
   end

   for (genvar s = 0; s < NUM_SPK; s++) begin : g_spk
      logic [CW-1:0] s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                          s_q <= CW'(DEF_SPK);
         else if (wr_ok && wr_addr_i == AW'(ADDR_SPK_BASE + s)) s_q <= wr_data_i;
      end
      assign spk_all[s] = s_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q <= CW'(DEF_HOLD);
         mode_q <= MODE_FAST;
      end else if (!en_i) begin
         mode_q <= (mode_i == 2'd3) ? MODE_FAST : mode_i;
         if (wr_en_i && wr_addr_i == AW'(ADDR_HOLD) && wr_data_i != '0)
            hold_q <= wr_data_i;
      end
   end

   always_comb begin
      unique case (mode_q)
         MODE_STD: begin
            sel_hcnt_o = hcnt_all[0];
            sel_lcnt_o = lcnt_all[0];
         end
         MODE_HS: begin
            sel_hcnt_o = hcnt_all[2];
            sel_lcnt_o = lcnt_all[2];
         end
         default: begin
            sel_hcnt_o = hcnt_all[1];
            sel_lcnt_o = lcnt_all[1];
         end
      endcase
      sel_spk_o = (mode_q == MODE_HS) ? spk_all[1] : spk_all[0];
   end

   assign hold_o = hold_q;

endmodule

// File: rtl/scl_gen_phase.sv
module scl_gen_phase
   import scl_gen_pkg::*;
#(
   parameter int unsigned CW = 16,
   parameter int unsigned TW = CW + 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic [CW-1:0] hcnt_i,
   input  logic [CW-1:0] lcnt_i,
   input  logic [CW-1:0] spk_i,
   output phase_e        phase_o,
   output logic [TW-1:0] cnt_o
);

   phase_e        phase_q;
   logic [TW-1:0] cnt_q;
   logic [TW-1:0] high_term;
   logic [TW-1:0] low_term;

   assign high_term = TW'(hcnt_i) + TW'(spk_i) + TW'(PHASE_FIXED - 1);
   assign low_term  = TW'(lcnt_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (!en_i) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               phase_q <= PH_HIGH;
               cnt_q   <= high_term;
            end
            PH_HIGH: begin
               if (cnt_q == '0) begin
                  phase_q <= PH_LOW;
                  cnt_q   <= low_term;
               end else begin
                  cnt_q <= cnt_q - TW'(1);
               end
            end
            PH_LOW: begin
               if (cnt_q == '0) begin
                  phase_q <= PH_HIGH;
                  cnt_q   <= high_term;
               end else begin
                  cnt_q <= cnt_q - TW'(1);
               end
            end
            default: begin
               phase_q <= PH_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign phase_o = phase_q;
   assign cnt_o   = cnt_q;

endmodule

// File: rtl/scl_gen_hold.sv
module scl_gen_hold
   import scl_gen_pkg::*;
#(
   parameter int unsigned CW = 16,
   parameter int unsigned TW = CW + 2
) (
   input  phase_e        phase_i,
   input  logic [TW-1:0] cnt_i,
   input  logic [CW-1:0] lcnt_i,
   input  logic [CW-1:0] hold_i,
   output logic          strobe_o
);

   logic [CW-1:0] hold_eff;
   logic [CW-1:0] target;

   assign hold_eff = (hold_i > lcnt_i) ? lcnt_i : hold_i;
   assign target   = lcnt_i - hold_eff;
   assign strobe_o = (phase_i == PH_LOW) && (cnt_i == TW'(target));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
   import scl_gen_pkg::*;
#(
   parameter int unsigned CW       = 16,
   parameter int unsigned AW       = 4,
   parameter int unsigned DEF_HCNT = 8,
   parameter int unsigned DEF_LCNT = 12,
   parameter int unsigned DEF_SPK  = 1,
   parameter int unsigned DEF_HOLD = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [CW-1:0] wr_data_i,
   input  logic [1:0]    mode_i,
   output logic          scl_low_o,
   output logic          phase_high_o,
   output logic          sda_strobe_o
);

   localparam int unsigned TW = CW + 2;

   if (CW < 4 || CW > 24) begin : g_bad_cw
      $error("scl_timing_gen: CW must lie in 4..24");
   end
   if (AW < 4) begin : g_bad_aw
      $error("scl_timing_gen: AW must reach address 8");
   end
   if (DEF_HOLD == 0) begin : g_bad_hold
      $error("scl_timing_gen: DEF_HOLD must be nonzero");
   end
   if (DEF_HCNT >= (1 << CW) || DEF_LCNT >= (1 << CW) || DEF_SPK >= (1 << CW)) begin : g_bad_def
      $error("scl_timing_gen: default counts exceed CW");
   end

   logic [CW-1:0] sel_hcnt;
   logic [CW-1:0] sel_lcnt;
   logic [CW-1:0] sel_spk;
   logic [CW-1:0] hold_val;
   phase_e        phase;
   logic [TW-1:0] cnt;

   scl_gen_regs #(
      .CW(CW), .AW(AW), .DEF_HCNT(DEF_HCNT), .DEF_LCNT(DEF_LCNT),
      .DEF_SPK(DEF_SPK), .DEF_HOLD(DEF_HOLD)
   ) regs_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .mode_i     (mode_i),
      .sel_hcnt_o (sel_hcnt),
      .sel_lcnt_o (sel_lcnt),
      .sel_spk_o  (sel_spk),
      .hold_o     (hold_val)
   );

   scl_gen_phase #(.CW(CW), .TW(TW)) phase_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .hcnt_i  (sel_hcnt),
      .lcnt_i  (sel_lcnt),
      .spk_i   (sel_spk),
      .phase_o (phase),
      .cnt_o   (cnt)
   );

   scl_gen_hold #(.CW(CW), .TW(TW)) hold_i (
      .phase_i  (phase),
      .cnt_i    (cnt),
      .lcnt_i   (sel_lcnt),
      .hold_i   (hold_val),
      .strobe_o (sda_strobe_o)
   );

   assign scl_low_o    = (phase == PH_LOW);
   assign phase_high_o = (phase == PH_HIGH);

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk #(
   parameter int unsigned CW = 16
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          en_i,
   input logic          scl_low_o,
   input logic          phase_high_o,
   input logic          sda_strobe_o,
   input logic [CW-1:0] sel_hcnt,
   input logic [CW-1:0] sel_lcnt,
   input logic [CW-1:0] sel_spk,
   input logic [CW-1:0] hold_val
);

   localparam int unsigned LW = CW + 4;

   logic [LW-1:0] hi_len_q;
   logic [LW-1:0] lo_len_q;
   logic [LW-1:0] exp_hi;
   logic [LW-1:0] exp_lo;

   assign exp_hi = LW'(sel_hcnt) + LW'(sel_spk) + LW'(7);
   assign exp_lo = LW'(sel_lcnt) + LW'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_len_q <= '0;
         lo_len_q <= '0;
      end else begin
         hi_len_q <= phase_high_o ? hi_len_q + LW'(1) : '0;
         lo_len_q <= scl_low_o    ? lo_len_q + LW'(1) : '0;
      end
   end

   a_r1_high_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(phase_high_o) && scl_low_o) |-> (hi_len_q == exp_hi));

   a_r2_low_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(phase_high_o) && $past(scl_low_o)) |-> (lo_len_q == exp_lo));

   a_r2_phase_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({scl_low_o, phase_high_o}));

   a_r5_strobe_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sda_strobe_o |-> scl_low_o);

   a_r5_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sda_strobe_o |=> !sda_strobe_o);

   a_r6_hold_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_val != '0);

   a_r7_frozen_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && $past(en_i)) |-> ($stable(sel_hcnt) && $stable(sel_lcnt) &&
                                 $stable(sel_spk) && $stable(hold_val)));

   a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!scl_low_o && !phase_high_o));

endmodule

bind scl_timing_gen scl_timing_chk #(.CW(CW)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .en_i         (en_i),
   .scl_low_o    (scl_low_o),
   .phase_high_o (phase_high_o),
   .sda_strobe_o (sda_strobe_o),
   .sel_hcnt     (sel_hcnt),
   .sel_lcnt     (sel_lcnt),
   .sel_spk      (sel_spk),
   .hold_val     (hold_val)
);

// File: tb/scl_timing_gen_tb.sv
`timescale 1ns/1ps
module scl_timing_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  mode = 2'd1;
   logic        scl_low, phase_high, strobe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   scl_timing_gen dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .en_i         (en),
      .wr_en_i      (wr_en),
      .wr_addr_i    (wr_addr),
      .wr_data_i    (wr_data),
      .mode_i       (mode),
      .scl_low_o    (scl_low),
      .phase_high_o (phase_high),
      .sda_strobe_o (strobe)
   );

   // behavioural reference model
   int mh[3], ml[3], mspk[2], mhold, mmode, mph, mcnt;

   function automatic int m_high_term();
      return mh[mmode] + mspk[(mmode == 2) ? 1 : 0] + 6;
   endfunction

   function automatic bit m_strobe();
      int lo, hd;
      lo = ml[mmode];
      hd = (mhold > lo) ? lo : mhold;
      return (mph == 2) && ((lo - mcnt) == hd);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin mh[i] = 8; ml[i] = 12; end
         mspk[0] = 1; mspk[1] = 1; mhold = 3; mmode = 1; mph = 0; mcnt = 0;
      end else begin
         if (!en) begin
            mph = 0; mcnt = 0;
         end else begin
            case (mph)
               0: begin mph = 1; mcnt = m_high_term(); end
               1: if (mcnt == 0) begin mph = 2; mcnt = ml[mmode]; end else mcnt--;
               default: if (mcnt == 0) begin mph = 1; mcnt = m_high_term(); end else mcnt--;
            endcase
         end
         if (!en) begin
            mmode = (mode == 2'd3) ? 1 : int'(mode);
            if (wr_en) begin
               if (wr_addr <= 4'd5) begin
                  if (wr_addr[0]) ml[wr_addr >> 1] = int'(wr_data);
                  else            mh[wr_addr >> 1] = int'(wr_data);
               end else if (wr_addr == 4'd6) mspk[0] = int'(wr_data);
               else if (wr_addr == 4'd7) mspk[1] = int'(wr_data);
               else if (wr_addr == 4'd8 && wr_data != 0) mhold = int'(wr_data);
            end
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         string tg;
         tg = (mph == 1) ? "R1 phase" : ((mph == 2) ? "R2 phase" : "R8 idle");
         chk({tg, " scl_low"}, int'(scl_low), (mph == 2) ? 1 : 0);
         chk({tg, " phase_high"}, int'(phase_high), (mph == 1) ? 1 : 0);
         chk("R5 sda strobe", int'(strobe), int'(m_strobe()));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic measure(output int hl, output int ll, output int sidx);
      while (!scl_low) @(negedge clk);
      while (!phase_high) @(negedge clk);
      hl = 0;
      while (phase_high) begin hl++; @(negedge clk); end
      ll = 0; sidx = -1;
      while (scl_low) begin
         if (strobe) sidx = ll;
         ll++;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int hl, ll, si;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state: released bus
      chk("R9 reset scl_low", int'(scl_low), 0);
      chk("R9 reset phase_high", int'(phase_high), 0);
      chk("R9 reset strobe", int'(strobe), 0);

      // R9 defaults in fast mode
      en = 1'b1;
      measure(hl, ll, si);
      chk("R9 default high", hl, 16);
      chk("R9 default low", ll, 13);
      chk("R9 default strobe", si, 3);

      // R3 R4 R5 standard mode with fast spike register
      @(negedge clk); en = 1'b0;
      wr(0, 5); wr(1, 9); wr(6, 2); wr(8, 4);
      mode = 2'd0;
      @(negedge clk); en = 1'b1;
      measure(hl, ll, si);
      chk("R3 R4 std high", hl, 14);
      chk("R2 std low", ll, 10);
      chk("R5 std strobe", si, 4);

      // R4 high-speed with its own spike; R5 clip at LCNT
      @(negedge clk); en = 1'b0;
      wr(4, 2); wr(5, 3); wr(7, 0);
      mode = 2'd2;
      @(negedge clk); en = 1'b1;
      measure(hl, ll, si);
      chk("R4 hs high", hl, 9);
      chk("R2 hs low", ll, 4);
      chk("R5 hs strobe clipped", si, 3);

      // R3 code 3 maps to fast pair
      @(negedge clk); en = 1'b0;
      mode = 2'd3;
      @(negedge clk); en = 1'b1;
      measure(hl, ll, si);
      chk("R3 mode3 high", hl, 17);
      chk("R3 mode3 low", ll, 13);

      // R7 writes and mode change while enabled are ignored
      wr(2, 1); wr(3, 1); wr(6, 9);
      mode = 2'd0;
      measure(hl, ll, si);
      chk("R7 high unchanged", hl, 17);
      chk("R7 low unchanged", ll, 13);

      // R6 zero write to hold ignored
      @(negedge clk); en = 1'b0;
      wr(8, 0);
      mode = 2'd1;
      @(negedge clk); en = 1'b1;
      measure(hl, ll, si);
      chk("R6 hold kept", si, 4);

      // R8 drop enable mid-phase, then fresh full high phase
      while (!scl_low) @(negedge clk);
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk("R8 released scl_low", int'(scl_low), 0);
      chk("R8 released phase_high", int'(phase_high), 0);
      en = 1'b1;
      @(negedge clk);
      hl = 0;
      while (phase_high) begin hl++; @(negedge clk); end
      chk("R8 first high full", hl, 17);

      // R1 R2 R5 minimum configuration
      @(negedge clk); en = 1'b0;
      wr(2, 0); wr(3, 0); wr(6, 0);
      @(negedge clk); en = 1'b1;
      measure(hl, ll, si);
      chk("R1 min high", hl, 7);
      chk("R2 min low", ll, 1);
      chk("R5 min strobe", si, 0);
      measure(hl, ll, si);
      chk("R1 min high repeat", hl, 7);

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule